// File: doc/BRIEF.md
# Floating-Point Control and Status Register Pair

This block holds the two software-visible registers of a small floating-point unit: a control register and a status register. The control register's two low bits choose the rounding direction. The block decodes them and drives the result straight to the arithmetic units. The status register gathers exception flags. Each cycle the datapath reports any flags raised by the operations that completed, and the block merges them into a sticky set. Software sees the accumulated set when it reads the status register.

Software writes either register through a single write port, choosing the target with a select bit. It reads either register through a combinational read port. A control write that puts a non-zero value in the must-be-zero upper field is discarded, and the block raises a one-cycle error pulse. A status write overwrites the whole sticky set. The only way to clear a flag is to write the status register.

Top module: `fpcsr_unit`

## Requirements
- R1: After reset the control register reads 0, the status register reads 0, `roundMode` is 0 (nearest-even) and `mbzErr` is low.
- R2: A control write (`wrSel`=0) with bits 31:12 all zero stores bits 6:0 only. A control read (`rdSel`=0) returns those seven bits, with bits 31:7 read as zero, from the cycle after the write edge.
- R3: A control write with any of bits 31:12 set leaves the control register unchanged. `mbzErr` is high for exactly the one cycle after that write edge and low otherwise.
- R4: `roundMode` equals control bits 1:0, encoded as 0 = nearest-even, 1 = toward zero, 2 = toward +infinity, 3 = toward -infinity.
- R5: A status read (`rdSel`=1) returns the flags in bits 11:7, with every other bit zero. The flags sit as follows: bit 7 inexact, bit 8 underflow, bit 9 overflow, bit 10 divide-by-zero, bit 11 invalid. `flagReport` bit i maps to status bit 7+i.
- R6: Flags reported on `flagReport` are ORed into the sticky set at the clock edge. A set flag stays set through idle cycles until a status write.
- R7: A status write (`wrSel`=1) replaces the sticky set with write bits 11:7. All other write bits are ignored, and the control register is unaffected.
- R8: When a status write and a flag report fall in the same cycle, the stored set is the written flags ORed with the reported flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 1 | Write target: 0 control, 1 status |
| wrData | input | 32 | Write data |
| rdSel | input | 1 | Read target: 0 control, 1 status |
| rdData | output | 32 | Read data (combinational from the registers) |
| flagReport | input | 5 | Exception flags raised by the datapath this cycle |
| roundMode | output | 2 | Decoded rounding direction |
| mbzErr | output | 1 | One-cycle pulse after a rejected control write |

## Verification
Every register update, whether from a write or from a flag report, is due in the cycle after the clock edge that samples it. Both `rdData` and `roundMode` show the new value from that cycle onward, and `mbzErr` is high during that cycle only. The bench drives inputs on falling edges and lets exactly one rising edge pass. It then checks reads and the error pulse before the next rising edge. It checks again one cycle later to confirm that flags are sticky and that the pulse has ended. It sweeps all 128 control values, all twenty must-be-zero bit positions, and every pairing of 32 written flag sets with 32 reported flag sets, both in separate cycles and in the same cycle.

// File: rtl/fpcsr_pkg.sv
package fpcsr_pkg;

  // Strobes passed from the write decoder to the register datapath.
  typedef struct packed {
    logic ctrlWr;  // accepted control write
    logic statWr;  // status write (replaces the flag set)
    logic mbzHit;  // rejected control write
  } csrStrobe_t;

  typedef enum logic [1:0] {
    RM_NEAREST_EVEN = 2'd0,
    RM_TO_ZERO      = 2'd1,
    RM_TO_POS_INF   = 2'd2,
    RM_TO_NEG_INF   = 2'd3
  } roundMode_e;

endpackage

// File: rtl/fpcsr_ctrl.sv
module fpcsr_ctrl
  import fpcsr_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int MBZ_LSB = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              wrSel,
  input  logic [DATA_W-1:0] wrData,
  output csrStrobe_t        strobe,
  output logic              mbzErr
);

  localparam int MBZ_W = DATA_W - MBZ_LSB;

  logic mbzNonZero;
  logic errQ;

  assign mbzNonZero = (wrData[DATA_W-1:MBZ_LSB] != {MBZ_W{1'b0}});

  always_comb begin
    strobe.mbzHit = wrEn && !wrSel && mbzNonZero;
    strobe.ctrlWr = wrEn && !wrSel && !mbzNonZero;
    strobe.statWr = wrEn && wrSel;
  end

  always_ff @(posedge clk) begin
    if (!rstN) errQ <= 1'b0;
    else       errQ <= strobe.mbzHit;
  end

  assign mbzErr = errQ;

  // R3
  reject_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.mbzHit |-> !strobe.ctrlWr && !strobe.statWr);

  // R3
  err_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.mbzHit |=> !mbzErr);

endmodule

// File: rtl/fpcsr_dpath.sv
module fpcsr_dpath
  import fpcsr_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int CTRL_W   = 7,
  parameter int FLAG_LSB = 7,
  parameter int FLAG_N   = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  csrStrobe_t        strobe,
  input  logic [DATA_W-1:0] wrData,
  input  logic [FLAG_N-1:0] flagReport,
  input  logic              rdSel,
  output logic [DATA_W-1:0] rdData,
  output logic [1:0]        roundMode
);

  logic [CTRL_W-1:0] ctrlQ;
  logic [FLAG_N-1:0] flagQ;

  always_ff @(posedge clk) begin
    if (!rstN)              ctrlQ <= '0;
    else if (strobe.ctrlWr) ctrlQ <= wrData[CTRL_W-1:0];
  end

  // One sticky cell per exception flag: a status write loads it first, then
  // a report from the same cycle is ORed on top.
  for (genvar i = 0; i < FLAG_N; i++) begin : g_flag
    logic baseBit;
    assign baseBit = strobe.statWr ? wrData[FLAG_LSB+i] : flagQ[i];
    always_ff @(posedge clk) begin
      if (!rstN) flagQ[i] <= 1'b0;
      else       flagQ[i] <= baseBit | flagReport[i];
    end
  end

  always_comb begin
    rdData = '0;
    if (rdSel) rdData[FLAG_LSB +: FLAG_N] = flagQ;
    else       rdData[CTRL_W-1:0]         = ctrlQ;
  end

  assign roundMode = ctrlQ[1:0];

  // R6
  flags_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.statWr |=> ((flagQ & $past(flagQ)) == $past(flagQ)));

  // R6
  report_merge_chk: assert property (@(posedge clk) disable iff (!rstN)
    (flagReport != '0) |=> ((flagQ & $past(flagReport)) == $past(flagReport)));

  // R7
  ctrl_isolated_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.ctrlWr |=> $stable(ctrlQ));

  // R5
  stat_zero_bits_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdSel |-> (rdData & ~({{(DATA_W-FLAG_N){1'b0}}, {FLAG_N{1'b1}}} << FLAG_LSB)) == '0);

endmodule

// File: rtl/fpcsr_unit.sv
module fpcsr_unit
  import fpcsr_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int CTRL_W   = 7,
  parameter int FLAG_LSB = 7,
  parameter int FLAG_N   = 5,
  parameter int MBZ_LSB  = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              wrSel,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdSel,
  output logic [DATA_W-1:0] rdData,
  input  logic [FLAG_N-1:0] flagReport,
  output logic [1:0]        roundMode,
  output logic              mbzErr
);

  csrStrobe_t strobe;

  fpcsr_ctrl #(.DATA_W(DATA_W), .MBZ_LSB(MBZ_LSB)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .strobe(strobe), .mbzErr(mbzErr)
  );

  fpcsr_dpath #(.DATA_W(DATA_W), .CTRL_W(CTRL_W), .FLAG_LSB(FLAG_LSB),
                .FLAG_N(FLAG_N)) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData),
    .flagReport(flagReport), .rdSel(rdSel), .rdData(rdData),
    .roundMode(roundMode)
  );

  // R3
  reject_keeps_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !wrSel && wrData[DATA_W-1:MBZ_LSB] != '0) |=> mbzErr && $stable(roundMode));

  // R4
  mode_matches_ctrl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rdSel |-> roundMode == rdData[1:0]);

  // R2
  ctrl_upper_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rdSel |-> rdData[DATA_W-1:CTRL_W] == '0);

endmodule

// File: tb/test_fpcsr_unit.sv
module test_fpcsr_unit;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic        wrSel = 1'b0;
  logic [31:0] wrData = '0;
  logic        rdSel = 1'b0;
  logic [31:0] rdData;
  logic [4:0]  flagReport = '0;
  logic [1:0]  roundMode;
  logic        mbzErr;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  fpcsr_unit i_fpcsr_unit (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .rdSel(rdSel), .rdData(rdData), .flagReport(flagReport),
    .roundMode(roundMode), .mbzErr(mbzErr)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected < 150000", cycles);
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic readReg(input logic sel, output logic [31:0] val);
    rdSel = sel;
    #0.5;
    val = rdData;
  endtask

  // Drive one write (and a report) for one edge; returns in the next cycle.
  task automatic cycleOp(input logic we, input logic sel, input logic [31:0] d,
                         input logic [4:0] rep);
    @(negedge clk);
    wrEn = we; wrSel = sel; wrData = d; flagReport = rep;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0; flagReport = '0;
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    readReg(1'b0, v); check("R1 ctrl", v, 32'h0);
    readReg(1'b1, v); check("R1 status", v, 32'h0);
    check("R1 roundMode", {30'd0, roundMode}, 32'd0);
    check("R1 mbzErr", {31'd0, mbzErr}, 32'd0);

    // R2 / R4 sweep of all control values, junk in bits 11:7
    for (int c = 0; c < 128; c++) begin
      cycleOp(1'b1, 1'b0, c | (((c * 37) & 32'h1F) << 7), 5'd0);
      readReg(1'b0, v); check("R2 ctrl read", v, c);
      check("R4 roundMode", {30'd0, roundMode}, c & 3);
      check("R3 no err", {31'd0, mbzErr}, 32'd0);
    end

    // R3 rejected writes on every must-be-zero bit
    cycleOp(1'b1, 1'b0, 32'h55, 5'd0);
    for (int k = 12; k < 32; k++) begin
      cycleOp(1'b1, 1'b0, (32'h1 << k) | 32'h2A, 5'd0);
      check("R3 err pulse", {31'd0, mbzErr}, 32'd1);
      readReg(1'b0, v); check("R3 ctrl kept", v, 32'h55);
      check("R3 mode kept", {30'd0, roundMode}, 32'd1);
      @(negedge clk);
      check("R3 err ends", {31'd0, mbzErr}, 32'd0);
    end

    // R5 single-bit positions
    for (int b = 0; b < 5; b++) begin
      cycleOp(1'b1, 1'b1, 32'h0, 5'd0);
      cycleOp(1'b0, 1'b0, 32'h0, 5'(1 << b));
      readReg(1'b1, v); check("R5 flag position", v, 32'h1 << (7 + b));
    end

    // R6 / R7 sweep: write then report in separate cycles
    for (int s = 0; s < 32; s++) begin
      for (int r = 0; r < 32; r++) begin
        cycleOp(1'b1, 1'b1, (s << 7) | 32'hFFFF_F07F, 5'd0);
        readReg(1'b1, v); check("R7 status write", v, s << 7);
        cycleOp(1'b0, 1'b0, 32'h0, 5'(r));
        readReg(1'b1, v); check("R6 merge", v, (s | r) << 7);
        @(negedge clk);
        readReg(1'b1, v); check("R6 sticky", v, (s | r) << 7);
      end
    end
    readReg(1'b0, v); check("R7 ctrl untouched", v, 32'h55);

    // R8 same-cycle write and report
    for (int s = 0; s < 32; s++) begin
      for (int r = 0; r < 32; r++) begin
        cycleOp(1'b1, 1'b1, s << 7, 5'(r));
        readReg(1'b1, v); check("R8 write plus report", v, (s | r) << 7);
      end
    end

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule